// File: doc/BRIEF.md
# Slow-Tick Synchronized Register Write Port

This block accepts register writes from a fast host bus and applies them to a small bank of timekeeping registers. Those registers may only change on a slow synchronization tick. An accepted write is held in a single capture register and marked pending. The next sync tick commits it to the target register, drops the pending flag and raises a sticky completion flag. A commit strobe that carries the target index and data is also presented to the counters outside the block. While a write is pending, every further write to a synchronized register is thrown away; the block does not queue it.

The status register sits just above the synchronized registers in the address map. It does not use the slow path. Writes to it act on the next clock edge, and its completion bit is cleared by writing a one to it. The sync tick comes from a raw slow pulse that arrives in the host clock domain. With the prescaler enable set, only one raw pulse in every `DIVIDE` produces a tick. With it clear, every raw pulse produces a tick, which makes commits much faster when the host needs them quickly.

Top module: `slow_sync_wrport`

## Requirements
- R1: After reset, every synchronized register and the status register read as zero, and the pending, completion and commit outputs are 0.
- R2: A write to a synchronized register (address below `NUM_REGS`) while nothing is pending is captured at that clock edge. From the next cycle, `pending_o` is 1 and bit 14 of the status register (address `NUM_REGS`) reads 1.
- R3: A read of a synchronized register returns its committed value and never the value waiting in the capture register.
- R4: On the first edge at which a pending write meets an active sync tick, the target register takes the captured data. In the cycle after that edge, `pending_o` is 0, `complete_o` is 1 and `commit_o` is 1 for exactly that one cycle.
- R5: A write to a synchronized register made while a write is pending is dropped, including one in the same cycle as the committing tick. The captured address and data are left unchanged.
- R6: The completion flag (status bit 15) stays set until a status write with bit 15 at 1 clears it at the next edge. A status write with bit 15 at 0 leaves it unchanged. Status writes never change the pending state.
- R7: If a commit and a clearing status write occur at the same edge, the completion flag ends up set.
- R8: With `pren_i` at 1, a sync tick is active in the cycle after every `DIVIDE`-th raw tick pulse. With `pren_i` at 0, it is active in the cycle after every raw pulse, and the divider count returns to zero.
- R9: A write to an address above `NUM_REGS` has no effect, and a read of such an address returns zero.
- R10: While `commit_o` is 1, `commit_addr_o` and `commit_data_o` carry the index and data of the write that was committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_i | input | 1 | Synchronous reset, active high |
| raw_tick_i | input | 1 | Raw slow tick pulse, host clock domain |
| pren_i | input | 1 | Prescaler enable: 1 divides raw ticks by DIVIDE |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| pending_o | output | 1 | A captured write waits for a tick |
| complete_o | output | 1 | Sticky completion flag |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_addr_o | output | IDX_W | Index of the committed register |
| commit_data_o | output | DATA_W | Data of the committed write |

## Verification
The bench builds the block with `NUM_REGS` = 4, `ADDR_W` = 4 and `DIVIDE` = 4. This leaves eleven unmapped addresses above the status register. It also means a prescaled commit needs only four raw pulses, so the divided and undivided tick paths, the write-during-tick drop and the set-versus-clear collision all come up many times within a few thousand random cycles.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int PEND_BIT = 14;
    localparam int DONE_BIT = 15;

    typedef enum logic [1:0] {
        ACC_SYNC = 2'd0,
        ACC_STAT = 2'd1,
        ACC_NONE = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e addr_kind(input logic [31:0] addr, input int unsigned nregs);
        if (addr < nregs) begin
            return ACC_SYNC;
        end else if (addr == nregs) begin
            return ACC_STAT;
        end
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/swp_tick_gen.sv
module swp_tick_gen #(
    parameter int unsigned DIVIDE = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_tick_i,
    input  logic pren_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIVIDE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (!pren_i) begin
            s_d.cnt  = '0;
            s_d.tick = raw_tick_i;
        end else if (raw_tick_i) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = s_q.tick;

endmodule

// File: rtl/swp_hold.sv
module swp_hold #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              wr_sync_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_done_i,
    output logic              fire_o,
    output logic              pending_o,
    output logic              done_o,
    output logic              commit_o,
    output logic [IDX_W-1:0]  hold_idx_o,
    output logic [DATA_W-1:0] hold_data_o
);
    typedef struct packed {
        logic              pend;
        logic              done;
        logic              commit;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } hold_state_t;

    hold_state_t s_d, s_q;
    logic        fire;

    assign fire = s_q.pend & tick_i;

    always_comb begin
        s_d        = s_q;
        s_d.commit = fire;
        if (fire) begin
            s_d.pend = 1'b0;
        end else if (!s_q.pend && wr_sync_i) begin
            s_d.pend = 1'b1;
            s_d.idx  = wr_idx_i;
            s_d.data = wr_data_i;
        end
        if (fire) begin
            s_d.done = 1'b1;
        end else if (clr_done_i) begin
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fire_o      = fire;
    assign pending_o   = s_q.pend;
    assign done_o      = s_q.done;
    assign commit_o    = s_q.commit;
    assign hold_idx_o  = s_q.idx;
    assign hold_data_o = s_q.data;

endmodule

// File: rtl/swp_regbank.sv
module swp_regbank #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_d;

        always_comb begin
            val_d = regs_q[g];
            if (we_i && (wr_idx_i == IDX_W'(g))) begin
                val_d = wr_data_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= val_d;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_data_o = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/slow_sync_wrport.sv
module slow_sync_wrport #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned DIVIDE   = 32768,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              raw_tick_i,
    input  logic              pren_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pending_o,
    output logic              complete_o,
    output logic              commit_o,
    output logic [IDX_W-1:0]  commit_addr_o,
    output logic [DATA_W-1:0] commit_data_o
);
    import swp_pkg::*;

    acc_kind_e         wr_kind, rd_kind;
    logic              tick_w;
    logic              fire_w;
    logic              clr_w;
    logic              wr_sync_w;
    logic [IDX_W-1:0]  hold_addr_w;
    logic [DATA_W-1:0] hold_data_w;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] stat_rd;

    assign wr_kind   = addr_kind(32'(wr_addr_i), NUM_REGS);
    assign rd_kind   = addr_kind(32'(rd_addr_i), NUM_REGS);
    assign wr_sync_w = wr_en_i && (wr_kind == ACC_SYNC);
    assign clr_w     = wr_en_i && (wr_kind == ACC_STAT) && wr_data_i[DONE_BIT];

    swp_tick_gen #(
        .DIVIDE (DIVIDE)
    ) u_tick (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .raw_tick_i (raw_tick_i),
        .pren_i     (pren_i),
        .tick_o     (tick_w)
    );

    swp_hold #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_w),
        .wr_sync_i   (wr_sync_w),
        .wr_idx_i    (wr_addr_i[IDX_W-1:0]),
        .wr_data_i   (wr_data_i),
        .clr_done_i  (clr_w),
        .fire_o      (fire_w),
        .pending_o   (pending_o),
        .done_o      (complete_o),
        .commit_o    (commit_o),
        .hold_idx_o  (hold_addr_w),
        .hold_data_o (hold_data_w)
    );

    swp_regbank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (fire_w),
        .wr_idx_i  (hold_addr_w),
        .wr_data_i (hold_data_w),
        .rd_idx_i  (rd_addr_i[IDX_W-1:0]),
        .rd_data_o (bank_rd)
    );

    always_comb begin
        stat_rd           = '0;
        stat_rd[PEND_BIT] = pending_o;
        stat_rd[DONE_BIT] = complete_o;
    end

    always_comb begin
        unique case (rd_kind)
            ACC_SYNC: rd_data_o = bank_rd;
            ACC_STAT: rd_data_o = stat_rd;
            default:  rd_data_o = '0;
        endcase
    end

    assign commit_addr_o = hold_addr_w;
    assign commit_data_o = hold_data_w;

endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_w,
    input logic              clr_w,
    input logic              pending_o,
    input logic              complete_o,
    input logic              commit_o,
    input logic [IDX_W-1:0]  hold_addr_w,
    input logic [DATA_W-1:0] hold_data_w
);
    AST_COMMIT_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> (!pending_o && complete_o)); // R4
    AST_COMMIT_FROM_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> $past(pending_o && tick_w)); // R4
    AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |=> !commit_o); // R4
    AST_DROP_KEEPS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_o && !tick_w) |=> (pending_o && $stable(hold_addr_w) && $stable(hold_data_w))); // R5
    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (complete_o && !clr_w) |=> complete_o); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (pending_o && tick_w && clr_w) |=> complete_o); // R7
endmodule

bind slow_sync_wrport swp_checker #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_w      (tick_w),
    .clr_w       (clr_w),
    .pending_o   (pending_o),
    .complete_o  (complete_o),
    .commit_o    (commit_o),
    .hold_addr_w (hold_addr_w),
    .hold_data_w (hold_data_w)
);

// File: tb/slow_sync_wrport_test.sv
`timescale 1ns/1ps
module slow_sync_wrport_test;
    localparam int NREG = 4;
    localparam int AW   = 4;
    localparam int DW   = 32;
    localparam int DIV  = 4;
    localparam logic [AW-1:0] STAT = AW'(NREG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          raw = 1'b0, pren = 1'b0, we = 1'b0;
    logic [AW-1:0] wa = '0, ra = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rd;
    logic          pend, done, cmt;
    logic [1:0]    caddr;
    logic [DW-1:0] cdata;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [DW-1:0] m_reg [NREG];
    logic          m_pend, m_done, m_commit, m_tick;
    logic [1:0]    m_addr;
    logic [DW-1:0] m_data;
    logic [1:0]    m_caddr;
    logic [DW-1:0] m_cdata;
    int            m_cnt;

    always #2.5 clk = ~clk;

    slow_sync_wrport #(
        .NUM_REGS (NREG),
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .DIVIDE   (DIV)
    ) uut (
        .clk_i         (clk),
        .rst_i         (rst),
        .raw_tick_i    (raw),
        .pren_i        (pren),
        .wr_en_i       (we),
        .wr_addr_i     (wa),
        .wr_data_i     (wd),
        .rd_addr_i     (ra),
        .rd_data_o     (rd),
        .pending_o     (pend),
        .complete_o    (done),
        .commit_o      (cmt),
        .commit_addr_o (caddr),
        .commit_data_o (cdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = '0;
        if (a < AW'(NREG)) v = m_reg[a[1:0]];
        else if (a == STAT) begin
            v[15] = m_done;
            v[14] = m_pend;
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        m_pend = 0; m_done = 0; m_commit = 0; m_tick = 0;
        m_addr = '0; m_data = '0; m_caddr = '0; m_cdata = '0; m_cnt = 0;
    endtask

    task automatic model_edge(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic r, input logic p);
        logic fire, clr, ntick;
        fire = m_pend && m_tick;
        clr  = w && (a == STAT) && d[15];
        if (!p) begin
            ntick = r;
            m_cnt = 0;
        end else begin
            ntick = r && (m_cnt == DIV - 1);
            if (r) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
        end
        m_commit = fire;
        if (fire) begin
            m_reg[m_addr] = m_data;
            m_caddr = m_addr;
            m_cdata = m_data;
        end
        if (fire) m_done = 1'b1;
        else if (clr) m_done = 1'b0;
        if (fire) m_pend = 1'b0;
        else if (!m_pend && w && (a < AW'(NREG))) begin
            m_pend = 1'b1;
            m_addr = a[1:0];
            m_data = d;
        end
        m_tick = ntick;
    endtask

    task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic r, input logic p, input logic [AW-1:0] rda);
        we = w; wa = a; wd = d; raw = r; pren = p; ra = rda;
        @(posedge clk);
        model_edge(w, a, d, r, p);
        @(negedge clk);
        chk("R2 pending", 32'(pend), 32'(m_pend));
        chk("R6 complete", 32'(done), 32'(m_done));
        chk("R4 commit", 32'(cmt), 32'(m_commit));
        if (m_commit) begin
            chk("R10 commit addr", 32'(caddr), 32'(m_caddr));
            chk("R10 commit data", cdata, m_cdata);
        end
        chk("R3 read", rd, exp_rd(rda));
    endtask

    task automatic idle(input logic r, input logic p, input logic [AW-1:0] rda);
        step(1'b0, '0, '0, r, p, rda);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i <= NREG; i++) begin
            ra = AW'(i);
            #0.1;
            chk("R1 reset read", rd, '0);
        end
        chk("R1 reset flags", {29'd0, pend, done, cmt}, '0);

        // R2/R3/R4: write, then commit with undivided ticks
        step(1'b1, 4'd1, 32'hA5A5_0001, 1'b0, 1'b0, 4'd1);
        chk("R3 pending value hidden", rd, 32'h0);
        idle(1'b0, 1'b0, STAT);
        chk("R2 status pending bit", rd, 32'h0000_4000);
        idle(1'b1, 1'b0, 4'd1);
        idle(1'b0, 1'b0, 4'd1);
        chk("R4 committed value", rd, 32'hA5A5_0001);
        chk("R4 flags after commit", {29'd0, pend, done, cmt}, 32'd3);

        // R5: drop while pending, including on the tick cycle
        step(1'b1, 4'd2, 32'h1111_2222, 1'b0, 1'b0, 4'd2);
        step(1'b1, 4'd2, 32'h3333_4444, 1'b1, 1'b0, 4'd2);
        step(1'b1, 4'd3, 32'h5555_6666, 1'b0, 1'b0, 4'd2);
        chk("R5 first write kept", rd, 32'h1111_2222);
        idle(1'b0, 1'b0, 4'd3);
        chk("R5 dropped write leaves reg", rd, 32'h0);
        chk("R5 nothing pending", 32'(pend), 32'd0);

        // R6: W1C with 0 and 1
        step(1'b1, STAT, 32'h0000_4000, 1'b0, 1'b0, STAT);
        chk("R6 zero write keeps flag", 32'(done), 32'd1);
        step(1'b1, STAT, 32'h0000_8000, 1'b0, 1'b0, STAT);
        chk("R6 one write clears flag", 32'(done), 32'd0);

        // R7: commit and clear at the same edge
        step(1'b1, 4'd0, 32'hCAFE_0000, 1'b1, 1'b0, 4'd0);
        step(1'b1, STAT, 32'h0000_8000, 1'b0, 1'b0, 4'd0);
        chk("R7 set beats clear", 32'(done), 32'd1);
        chk("R7 commit happened", rd, 32'hCAFE_0000);

        // R9: unmapped address
        step(1'b1, 4'd9, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'd9);
        chk("R9 unmapped no pending", 32'(pend), 32'd0);
        chk("R9 unmapped reads zero", rd, 32'h0);

        // R8: divided ticks
        step(1'b1, 4'd3, 32'h0BAD_F00D, 1'b0, 1'b1, 4'd3);
        for (int k = 0; k < DIV - 1; k++) begin
            idle(1'b1, 1'b1, 4'd3);
            idle(1'b0, 1'b1, 4'd3);
        end
        chk("R8 still pending before last pulse", 32'(pend), 32'd1);
        idle(1'b1, 1'b1, 4'd3);
        idle(1'b0, 1'b1, 4'd3);
        chk("R8 commit after divide pulses", rd, 32'h0BAD_F00D);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic          w, r, p;
            logic [AW-1:0] a, rdx;
            logic [DW-1:0] d;
            w   = ($urandom % 3) == 0;
            a   = AW'($urandom % 8);
            d   = $urandom;
            r   = ($urandom % 4) == 0;
            p   = ((n / 500) % 2) == 1;
            rdx = AW'($urandom % 8);
            step(w, a, d, r, p, rdx);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule